// File: doc/BRIEF.md
# Link Training Sequencer

This block runs the two training phases that bring up a multi-lane serial display link: clock recovery first, then channel equalization. It does not touch the sideband channel itself. Instead it issues three kinds of handshaked requests to neighbouring logic:
- select a training pattern;
- commit the current drive settings, which are computed by a separate drive-adjust block;
- read back the sink's status bytes.

The block waits a programmable interval between each commit and the status read that follows it. It then judges the per-lane status and decides whether to retry, move on, or give up.

A rate-selection controller programs the link configuration and pulses `start`. At the same time it supplies:
- the number of active lanes;
- whether the sink supports the third training pattern;
- the sink's read-interval field.

It waits for `done` and reads `pass`. The time base is a one-microsecond tick, so the block runs from any core clock. A negative acknowledge on any commit or status read ends training at once with a failure.

Top module: `lt_sequencer`

## Requirements
- R1: After reset, and whenever no training is running, `busy` is low and none of `pat_req`, `cmt_req` or `sts_req` is asserted. At most one of the three requests is high in any cycle. `start` while busy is ignored.
- R2: Clock recovery first requests pattern 1 (`pat_val`=1). Each clock-recovery iteration then commits drive settings, waits, and reads status. Each request is held until its acknowledge or negative acknowledge.
- R3: The wait between a commit (or, for the first equalization read, the pattern acknowledge) and the status read lasts 4000·`rd_interval` ticks when `rd_interval` is nonzero. Otherwise it lasts 100 ticks in clock recovery and 400 ticks in equalization.
- R4: Lane i's status nibble is bits [4·(i mod 2)+3 : 4·(i mod 2)] of status byte i/2, where byte k is `sts_data[8k+7:8k]`. Nibble bit 0 is CR done. Only lanes below `lane_cnt` are evaluated. Clock recovery passes when every active lane has CR done.
- R5: When clock recovery has not passed, it aborts with failure if the lowest-numbered active lane lacking CR done has its `cmt_maxed` bit set in the latest commit. A max flag on any other lane does not abort.
- R6: The clock-recovery try count restarts whenever `cmt_swing0` differs from its last recorded value. The recorded value is 0 at `start`. Clock recovery fails when the count reaches 5, so 5 reads with unchanged lane-0 swing fail, and 9 reads fail when the swing changes on the 5th.
- R7: Equalization requests pattern 3 when `tps3_cap` was set at `start`, and pattern 2 otherwise. Its first status read follows the pattern acknowledge with no commit in between.
- R8: Equalization passes only when status byte 2 bit 0 (interlane align) is set and every active lane shows EQ done (nibble bit 1) and symbol locked (nibble bit 2).
- R9: Equalization that has not passed fails at once if any active lane lacks CR done. Otherwise it commits and retries, and it fails after the 6th unsuccessful read.
- R10: `cmt_pc2` is high on equalization commits exactly when `tps3_cap` was set, and is always low on clock-recovery commits.
- R11: A negative acknowledge on a commit or status read ends training with `done` high and `pass` low in the next cycle.
- R12: `done` is a one-cycle pulse with `busy` low. `pass` is valid with it and holds until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin training, sampled when idle |
| lane_cnt | input | $clog2(LANES+1) | Active lane count (1..LANES) |
| tps3_cap | input | 1 | Sink supports the third training pattern |
| rd_interval | input | RDI_W | Sink read-interval field, in 4 ms units |
| tick_us | input | 1 | One-microsecond time base strobe |
| pat_req | output | 1 | Pattern select request |
| pat_val | output | 2 | Requested training pattern |
| pat_ack | input | 1 | Pattern select done |
| cmt_req | output | 1 | Drive-setting commit request |
| cmt_pc2 | output | 1 | Commit includes post-cursor2 settings |
| cmt_ack | input | 1 | Commit done |
| cmt_nack | input | 1 | Commit failed |
| cmt_maxed | input | LANES | Per-lane max-swing flag of the committed setting, valid with cmt_ack |
| cmt_swing0 | input | 2 | Lane 0 committed swing level, valid with cmt_ack |
| sts_req | output | 1 | Status read request |
| sts_ack | input | 1 | Status read done |
| sts_nack | input | 1 | Status read failed |
| sts_data | input | 48 | Six status bytes, byte k at bits 8k+7:8k, valid with sts_ack |
| busy | output | 1 | Training in progress |
| done | output | 1 | Training finished (one cycle) |
| pass | output | 1 | Training result |

## Verification
Several status and drive-setting scripts are used:
- A clean first-try pass on four lanes, which sets the baseline request counts and pattern order.
- A case where equalization needs a retry, which separates the pattern-3 and post-cursor2 path from the pattern-2 path.
- Repeated clock-recovery failures with and without a lane-0 swing change, which show whether the try count restarts.
- Max-swing flags placed on the first failing lane and on a later lane, which distinguish abort from retry.
- Single-lane and two-lane runs with garbage in the inactive nibbles.
- A status set that has every lane equalized but no interlane alignment.
- Equalization with a lost CR bit, and six equalization reads that never succeed.

Negative acknowledges on each request type, and a nonzero read interval, measure the ending and the wait length.

// File: rtl/lt_seq_pkg.sv
package lt_seq_pkg;

   localparam logic [1:0] PAT_CR  = 2'd1;
   localparam logic [1:0] PAT_EQ  = 2'd2;
   localparam logic [1:0] PAT_EQ3 = 2'd3;

   localparam int STS_W     = 48;
   localparam int ALIGN_BIT = 16;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CR_PAT,
      ST_CR_CMT,
      ST_CR_WAIT,
      ST_CR_RD,
      ST_CR_EVAL,
      ST_EQ_PAT,
      ST_EQ_CMT,
      ST_EQ_WAIT,
      ST_EQ_RD,
      ST_EQ_EVAL
   } lt_state_e;

endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
   parameter int TW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   input  logic          run,
   input  logic          tick,
   output logic          expired
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (load)                      cnt <= load_val;
      else if (run && tick && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/lt_lane_eval.sv
module lt_lane_eval
   import lt_seq_pkg::*;
#(
   parameter int LANES = 4,
   localparam int LCW  = $clog2(LANES + 1)
) (
   input  logic [STS_W-1:0] sts,
   input  logic [LANES-1:0] maxed,
   input  logic [LCW-1:0]   lanes,
   output logic             all_cr,
   output logic             all_eq,
   output logic             fail_at_max
);

   logic [LANES-1:0] miss_cr;
   logic [LANES-1:0] eq_ok;
   logic [LANES-1:0] nib_hi;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [LCW-1:0] IDX = LCW'(i);
      localparam int             POS = (i / 2) * 8 + (i % 2) * 4;
      logic [3:0] nib;
      logic       act;
      assign nib        = sts[POS +: 4];
      assign act        = (IDX < lanes);
      assign miss_cr[i] = act & ~nib[0];
      assign eq_ok[i]   = ~act | (nib[1] & nib[2]);
      assign nib_hi[i]  = nib[3];
   end

   always_comb begin
      fail_at_max = 1'b0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (miss_cr[i]) fail_at_max = maxed[i];
      end
   end

   assign all_cr = ~|miss_cr;
   assign all_eq = (&eq_ok) & sts[ALIGN_BIT];

   logic unused_sts;
   assign unused_sts = ^{nib_hi, sts[STS_W-1:ALIGN_BIT+1], sts[ALIGN_BIT-1:LANES*4]};

endmodule

// File: rtl/lt_sequencer.sv
module lt_sequencer
   import lt_seq_pkg::*;
#(
   parameter int LANES       = 4,
   parameter int RDI_W       = 8,
   parameter int US_PER_MS   = 1000,
   parameter int CR_WAIT_US  = 100,
   parameter int EQ_WAIT_US  = 400,
   parameter int CR_MAX_TRY  = 5,
   parameter int EQ_MAX_RTY  = 5,
   localparam int LCW        = $clog2(LANES + 1),
   localparam int MS_TICKS   = 4 * US_PER_MS,
   localparam int TW         = $clog2((2**RDI_W - 1) * MS_TICKS + EQ_WAIT_US + CR_WAIT_US + 1),
   localparam int CRW        = $clog2(CR_MAX_TRY + 1),
   localparam int EQW        = $clog2(EQ_MAX_RTY + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LCW-1:0]   lane_cnt,
   input  logic             tps3_cap,
   input  logic [RDI_W-1:0] rd_interval,
   input  logic             tick_us,
   output logic             pat_req,
   output logic [1:0]       pat_val,
   input  logic             pat_ack,
   output logic             cmt_req,
   output logic             cmt_pc2,
   input  logic             cmt_ack,
   input  logic             cmt_nack,
   input  logic [LANES-1:0] cmt_maxed,
   input  logic [1:0]       cmt_swing0,
   output logic             sts_req,
   input  logic             sts_ack,
   input  logic             sts_nack,
   input  logic [STS_W-1:0] sts_data,
   output logic             busy,
   output logic             done,
   output logic             pass
);

   if (LANES != 1 && LANES != 2 && LANES != 4) begin : g_bad_lanes
      $error("lt_sequencer: LANES must be 1, 2 or 4");
   end
   if (CR_MAX_TRY < 1 || EQ_MAX_RTY < 0) begin : g_bad_tries
      $error("lt_sequencer: retry limits out of range");
   end

   lt_state_e        state;
   logic [LCW-1:0]   lanes_q;
   logic             tps3_q;
   logic [RDI_W-1:0] rdi_q;
   logic [LANES-1:0] maxed_q;
   logic [1:0]       swing0_q;
   logic [1:0]       swing_ref;
   logic [STS_W-1:0] sts_q;
   logic [CRW-1:0]   cr_tries;
   logic [CRW-1:0]   cr_next;
   logic [EQW-1:0]   eq_tries;

   logic             all_cr, all_eq, fail_at_max;
   logic             tmr_load, tmr_exp, in_wait;
   logic [TW-1:0]    wait_len;

   lt_lane_eval #(.LANES(LANES)) u_eval (
      .sts         (sts_q),
      .maxed       (maxed_q),
      .lanes       (lanes_q),
      .all_cr      (all_cr),
      .all_eq      (all_eq),
      .fail_at_max (fail_at_max)
   );

   always_comb begin
      if (rdi_q != '0)
         wait_len = TW'(rdi_q) * TW'(MS_TICKS);
      else if (state == ST_CR_CMT)
         wait_len = TW'(CR_WAIT_US);
      else
         wait_len = TW'(EQ_WAIT_US);
   end

   assign tmr_load = ((state == ST_CR_CMT || state == ST_EQ_CMT) && cmt_ack && !cmt_nack)
                   || (state == ST_EQ_PAT && pat_ack);
   assign in_wait  = (state == ST_CR_WAIT) || (state == ST_EQ_WAIT);

   lt_wait_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (wait_len),
      .run      (in_wait),
      .tick     (tick_us),
      .expired  (tmr_exp)
   );

   assign cr_next = (swing0_q != swing_ref) ? CRW'(1) : cr_tries + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         lanes_q   <= '0;
         tps3_q    <= 1'b0;
         rdi_q     <= '0;
         maxed_q   <= '0;
         swing0_q  <= '0;
         swing_ref <= '0;
         sts_q     <= '0;
         cr_tries  <= '0;
         eq_tries  <= '0;
         done      <= 1'b0;
         pass      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               lanes_q   <= lane_cnt;
               tps3_q    <= tps3_cap;
               rdi_q     <= rd_interval;
               swing_ref <= '0;
               cr_tries  <= '0;
               pass      <= 1'b0;
               state     <= ST_CR_PAT;
            end
            ST_CR_PAT: if (pat_ack) state <= ST_CR_CMT;
            ST_CR_CMT, ST_EQ_CMT: begin
               if (cmt_nack) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end else if (cmt_ack) begin
                  maxed_q  <= cmt_maxed;
                  swing0_q <= cmt_swing0;
                  state    <= (state == ST_CR_CMT) ? ST_CR_WAIT : ST_EQ_WAIT;
               end
            end
            ST_CR_WAIT: if (tmr_exp) state <= ST_CR_RD;
            ST_EQ_WAIT: if (tmr_exp) state <= ST_EQ_RD;
            ST_CR_RD, ST_EQ_RD: begin
               if (sts_nack) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end else if (sts_ack) begin
                  sts_q <= sts_data;
                  state <= (state == ST_CR_RD) ? ST_CR_EVAL : ST_EQ_EVAL;
               end
            end
            ST_CR_EVAL: begin
               if (all_cr) begin
                  eq_tries <= '0;
                  state    <= ST_EQ_PAT;
               end else if (fail_at_max || cr_next >= CRW'(CR_MAX_TRY)) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  swing_ref <= swing0_q;
                  cr_tries  <= cr_next;
                  state     <= ST_CR_CMT;
               end
            end
            ST_EQ_PAT: if (pat_ack) state <= ST_EQ_WAIT;
            ST_EQ_EVAL: begin
               if (all_eq) begin
                  pass  <= 1'b1;
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end else if (!all_cr || eq_tries == EQW'(EQ_MAX_RTY)) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  eq_tries <= eq_tries + 1'b1;
                  state    <= ST_EQ_CMT;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign pat_req = (state == ST_CR_PAT) || (state == ST_EQ_PAT);
   assign pat_val = (state == ST_CR_PAT) ? PAT_CR : (tps3_q ? PAT_EQ3 : PAT_EQ);
   assign cmt_req = (state == ST_CR_CMT) || (state == ST_EQ_CMT);
   assign cmt_pc2 = (state == ST_EQ_CMT) && tps3_q;
   assign sts_req = (state == ST_CR_RD) || (state == ST_EQ_RD);
   assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/lt_sequencer_chk.sv
module lt_sequencer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       pat_req,
   input logic [1:0] pat_val,
   input logic       pat_ack,
   input logic       cmt_req,
   input logic       cmt_pc2,
   input logic       cmt_ack,
   input logic       cmt_nack,
   input logic       sts_req,
   input logic       sts_ack,
   input logic       sts_nack,
   input logic       done,
   input logic       pass
);

   logic [1:0] seen_pat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  seen_pat <= 2'd0;
      else if (pat_req && pat_ack) seen_pat <= pat_val;
   end

   p_one_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pat_req, cmt_req, sts_req}));

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(pat_req || cmt_req || sts_req));

   p_first_pat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (pat_req && pat_val == 2'd1));

   p_cmt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_req && !cmt_ack && !cmt_nack) |=> cmt_req);

   p_sts_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_req && !sts_ack && !sts_nack) |=> sts_req);

   p_pc2_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_req |-> (cmt_pc2 == (seen_pat == 2'd3)));

   p_nack_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmt_req && cmt_nack) || (sts_req && sts_nack)) |=> (done && !pass));

   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_pass_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$rose(busy) && !done) |-> $stable(pass));

endmodule

bind lt_sequencer lt_sequencer_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .pat_req  (pat_req),
   .pat_val  (pat_val),
   .pat_ack  (pat_ack),
   .cmt_req  (cmt_req),
   .cmt_pc2  (cmt_pc2),
   .cmt_ack  (cmt_ack),
   .cmt_nack (cmt_nack),
   .sts_req  (sts_req),
   .sts_ack  (sts_ack),
   .sts_nack (sts_nack),
   .done     (done),
   .pass     (pass)
);

// File: tb/lt_sequencer_tb.sv
module lt_sequencer_tb;

   localparam int LANES = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  lane_cnt = 3'd4;
   logic        tps3_cap = 1'b0;
   logic [7:0]  rd_interval = 8'd0;
   logic        pat_req, cmt_req, cmt_pc2, sts_req, busy, done, pass;
   logic [1:0]  pat_val;
   logic        pat_ack = 1'b0, cmt_ack = 1'b0, cmt_nack = 1'b0;
   logic        sts_ack = 1'b0, sts_nack = 1'b0;
   logic [3:0]  cmt_maxed = '0;
   logic [1:0]  cmt_swing0 = '0;
   logic [47:0] sts_data = '0;

   always #2.5 clk = ~clk;

   lt_sequencer #(.LANES(LANES)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .lane_cnt(lane_cnt),
      .tps3_cap(tps3_cap), .rd_interval(rd_interval), .tick_us(1'b1),
      .pat_req(pat_req), .pat_val(pat_val), .pat_ack(pat_ack),
      .cmt_req(cmt_req), .cmt_pc2(cmt_pc2), .cmt_ack(cmt_ack), .cmt_nack(cmt_nack),
      .cmt_maxed(cmt_maxed), .cmt_swing0(cmt_swing0),
      .sts_req(sts_req), .sts_ack(sts_ack), .sts_nack(sts_nack), .sts_data(sts_data),
      .busy(busy), .done(done), .pass(pass)
   );

   typedef struct {
      bit    ok;
      int    cmts;
      int    reads;
      int    pc2s;
      int    lastpat;
      int    wait_n;
      string tag;
   } exp_t;

   exp_t       exp_q[$];
   logic [5:0] conf_script[$];
   logic [47:0] sts_script[$];

   int  checks = 0, errors = 0;
   int  cyc = 0, ack_cyc = 0, gap = 0;
   int  n_cmt = 0, n_rd = 0, n_pc2 = 0, last_pat = 0;
   bit  nack_c = 0, nack_s = 0;

   task automatic chk(bit good, string req, int act, int expv);
      checks++;
      if (!good) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   // responder for the three request channels
   always @(negedge clk) begin
      cyc++;
      if (pat_req && !pat_ack) begin
         pat_ack = 1'b1; last_pat = int'(pat_val); ack_cyc = cyc;
      end else pat_ack = 1'b0;
      if (cmt_req && !cmt_ack && !cmt_nack) begin
         n_cmt++;
         if (cmt_pc2) n_pc2++;
         if (nack_c) cmt_nack = 1'b1;
         else begin
            logic [5:0] c;
            c = (conf_script.size() != 0) ? conf_script.pop_front() : 6'd0;
            cmt_ack = 1'b1; cmt_maxed = c[5:2]; cmt_swing0 = c[1:0];
         end
         ack_cyc = cyc;
      end else begin
         cmt_ack = 1'b0; cmt_nack = 1'b0;
      end
      if (sts_req && !sts_ack && !sts_nack) begin
         n_rd++;
         gap = cyc - ack_cyc;
         if (nack_s) sts_nack = 1'b1;
         else begin
            sts_ack = 1'b1;
            sts_data = (sts_script.size() != 0) ? sts_script.pop_front() : 48'd0;
         end
      end else begin
         sts_ack = 1'b0; sts_nack = 1'b0;
      end
   end

   // monitor: pops expectations when a run completes
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) chk(1'b0, "R12 unexpected done", 1, 0);
         else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(pass == e.ok, {e.tag, " result"}, int'(pass), int'(e.ok));
            chk(n_cmt == e.cmts, {e.tag, " commits"}, n_cmt, e.cmts);
            chk(n_rd == e.reads, {e.tag, " reads"}, n_rd, e.reads);
            chk(n_pc2 == e.pc2s, {e.tag, " R10 pc2 commits"}, n_pc2, e.pc2s);
            chk(last_pat == e.lastpat, {e.tag, " R2/R7 last pattern"}, last_pat, e.lastpat);
            if (e.wait_n > 0)
               chk(gap >= e.wait_n + 1 && gap <= e.wait_n + 3, {e.tag, " R3 wait"}, gap, e.wait_n + 2);
            chk(!busy, "R12 busy with done", int'(busy), 0);
         end
      end
   end

   task automatic run_case(int lanes, bit t3, int rdi, bit nc, bit ns,
                           bit ok, int cmts, int reads, int pc2s, int lp, int w, string tag);
      exp_t e;
      e.ok = ok; e.cmts = cmts; e.reads = reads; e.pc2s = pc2s;
      e.lastpat = lp; e.wait_n = w; e.tag = tag;
      @(negedge clk);
      n_cmt = 0; n_rd = 0; n_pc2 = 0; last_pat = 0;
      nack_c = nc; nack_s = ns;
      lane_cnt = 3'(lanes); tps3_cap = t3; rd_interval = 8'(rdi);
      exp_q.push_back(e);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lane_cnt = 3'd0; tps3_cap = ~t3;
      wait (exp_q.size() == 0);
      @(negedge clk);
      chk(!done, {tag, " R12 done pulse width"}, int'(done), 0);
      conf_script.delete(); sts_script.delete();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done, "R1 reset idle", int'(busy), 0);
      chk(!(pat_req || cmt_req || sts_req), "R1 reset no request", int'(pat_req), 0);

      // R2 R4 R8: clean pass on four lanes
      sts_script = '{48'h0000_0000_1111, 48'h0000_0001_7777};
      run_case(4, 0, 0, 0, 0, 1, 1, 2, 0, 2, 400, "R2 R4 R8 clean");

      // R7 R10: pattern 3, one equalization retry with post-cursor2 commit
      sts_script = '{48'h1111, 48'h1111, 48'h0000_0001_7777};
      run_case(4, 1, 0, 0, 0, 1, 2, 3, 1, 3, 400, "R7 R10 tps3");

      // R6: no swing change, five failing reads
      run_case(4, 0, 0, 0, 0, 0, 5, 5, 0, 1, 100, "R6 no change");

      // R6: swing change on the fifth commit restarts the count
      conf_script = '{6'd0, 6'd0, 6'd0, 6'd0, 6'd1, 6'd1, 6'd1, 6'd1, 6'd1};
      run_case(4, 0, 0, 0, 0, 0, 9, 9, 0, 1, 100, "R6 swing change");

      // R5: first failing lane (1) at max swing aborts
      conf_script = '{6'b0010_00};
      sts_script  = '{48'h0001};
      run_case(4, 0, 0, 0, 0, 0, 1, 1, 0, 1, 100, "R5 abort");

      // R5: max flag only on lane 3 while lane 2 is first to fail
      conf_script = '{6'b1000_00, 6'b1000_00, 6'b1000_00, 6'b1000_00, 6'b1000_00};
      sts_script  = '{48'h0011, 48'h0011, 48'h0011, 48'h0011, 48'h0011};
      run_case(4, 0, 0, 0, 0, 0, 5, 5, 0, 1, 100, "R5 later lane");

      // R4: single lane, inactive nibbles zero
      sts_script = '{48'h0001, 48'h0001_0007};
      run_case(1, 0, 0, 0, 0, 1, 1, 2, 0, 2, 400, "R4 one lane");

      // R8: all lanes equalized but align missing on first read
      sts_script = '{48'h0011, 48'h0077, 48'h0001_0077};
      run_case(2, 0, 0, 0, 0, 1, 2, 3, 0, 2, 400, "R8 align");

      // R9: CR lost on lane 1 during equalization
      sts_script = '{48'h1111, 48'h0001_7707};
      run_case(4, 0, 0, 0, 0, 0, 1, 2, 0, 2, 400, "R9 cr lost");

      // R9: six unsuccessful equalization reads
      sts_script = '{48'h1111, 48'h1111, 48'h1111, 48'h1111, 48'h1111, 48'h1111, 48'h1111};
      run_case(4, 1, 0, 0, 0, 0, 6, 7, 5, 3, 400, "R9 retries");

      // R11: status nack and commit nack
      run_case(4, 0, 0, 0, 1, 0, 1, 1, 0, 1, 100, "R11 sts nack");
      run_case(4, 0, 0, 1, 0, 0, 1, 0, 0, 1, 0, "R11 cmt nack");

      // R3: read-interval field overrides default waits
      sts_script = '{48'h1111, 48'h0000_0001_7777};
      run_case(4, 0, 1, 0, 0, 1, 1, 2, 0, 2, 4000, "R3 interval");

      // R1: start while busy is ignored (pulse mid-run)
      sts_script = '{48'h1111, 48'h0000_0001_7777};
      fork
         run_case(4, 0, 0, 0, 0, 1, 1, 2, 0, 2, 400, "R1 start busy");
         begin
            repeat (30) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
         end
      join
      repeat (5) @(negedge clk);
      chk(!busy, "R1 restart ignored", int'(busy), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule